// File: doc/BRIEF.md
# Frame Palette Loader and Color Lookup

This block receives a color palette at the start of every display frame and then turns pixel indices into colors. A frame begins with a one-cycle pulse on `frame_start_i`. After that pulse the block accepts a stream of 16-bit palette words and writes them into an internal 256 x 16 store, starting at address 0. The first word of each frame has two jobs. It is palette entry 0, and it also carries a 2-bit pixel-size code in bits 13:12. That code sets the pixel format for the whole frame, the number of palette words the block consumes, and whether color lookup is bypassed.

Once all palette words for the frame have been consumed, the block accepts pixel indices. Each accepted index yields one color, one cycle later. In the two palette modes the index addresses the store. In the bypass mode the index value itself is returned as the color. The latched frame format is presented on `mode_o` so that the pixel unpacker can split memory words correctly.

Top module: `frame_palette_lut`

## Requirements
- R1: After reset, `pal_ready_o`, `px_ready_o`, `col_valid_o` and `cfg_err_o` are 0, and `mode_o` is 0 (4-bit mode).
- R2: On the clock edge after a `frame_start_i` pulse, `pal_ready_o` is 1 and `px_ready_o` is 0. This holds whatever state the block was in.
- R3: A header code of 00 in bits 13:12 of the first word selects `mode_o`=0 (4 bits per pixel). The block then consumes exactly 16 palette words. After the edge that accepts the 16th word, `pal_ready_o` is 0 and `px_ready_o` is 1.
- R4: A header code of 01 selects `mode_o`=1 (8 bits per pixel). The block consumes exactly 256 palette words before `px_ready_o` rises.
- R5: A header code of 10 with `passive_i`=1 (sampled with the header word) selects `mode_o`=2 (12-bit pixels). The block consumes 16 dummy words. Each color output equals the index with bits 15:12 cleared.
- R6: A header code of 10 with `passive_i`=0 selects `mode_o`=3 (16-bit pixels). The block consumes 16 dummy words. Each color output equals the full 16-bit index.
- R7: A header code of 11 sets `cfg_err_o`=1 and is handled exactly like code 00. The flag stays set until a header with another code is accepted, which clears it.
- R8: In 4-bit mode only index bits 3:0 choose the palette entry. The color is the word that arrived at that position in the frame's palette stream, counting from 0.
- R9: In 8-bit mode only index bits 7:0 choose the palette entry, which covers all 256 stored words.
- R10: A pixel index is accepted only when `px_valid_i` and `px_ready_o` are both 1. `col_valid_o` is 1 exactly on the cycle after an accepted index, and `col_data_o` carries that index's color on that cycle. An index offered while palette words are still being loaded produces no output.
- R11: Palette entry 0 holds the complete first word, including its header bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| passive_i | input | 1 | Passive-panel select, sampled with the header word |
| frame_start_i | input | 1 | One-cycle pulse that starts a new frame and restarts palette loading |
| pal_valid_i | input | 1 | Palette word valid |
| pal_data_i | input | 16 | Palette word; the first word of a frame carries the code in bits 13:12 |
| pal_ready_o | output | 1 | Block is consuming palette words |
| px_valid_i | input | 1 | Pixel index valid |
| px_index_i | input | 16 | Pixel index, or the raw pixel value in bypass modes |
| px_ready_o | output | 1 | Block accepts pixel indices |
| col_valid_o | output | 1 | Color output valid |
| col_data_o | output | 16 | Color value |
| mode_o | output | 2 | Latched frame format: 0=4b, 1=8b, 2=12b, 3=16b |
| cfg_err_o | output | 1 | Reserved header code was seen in the current frame |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 256-entry store and a 16-entry small palette. With these values it can load a full 256-word palette and then read back the highest entry. Index patterns with stray high bits exercise the address masking in both palette modes. A reserved header followed by a valid one shows the error flag being set and then cleared. Both bypass variants are reached by toggling the passive input between frames.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  typedef enum logic [1:0] {
    PM_4B  = 2'd0,
    PM_8B  = 2'd1,
    PM_12B = 2'd2,
    PM_16B = 2'd3
  } pix_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/fpl_hdr_decode.sv
module fpl_hdr_decode
  import fpl_pkg::*;
(
  input  logic [1:0] code_i,
  input  logic       passive_i,
  output pix_mode_e  mode_o,
  output logic       reserved_o
);
  always_comb begin
    reserved_o = 1'b0;
    case (code_i)
      2'b00:   mode_o = PM_4B;
      2'b01:   mode_o = PM_8B;
      2'b10:   mode_o = passive_i ? PM_12B : PM_16B;
      default: begin
        mode_o     = PM_4B;
        reserved_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fpl_load_ctrl.sv
module fpl_load_ctrl
  import fpl_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int SMALL_W  = 4,
  parameter int CODE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_i,
  input  logic              pal_valid_i,
  input  logic [WORD_W-1:0] pal_data_i,
  input  logic              passive_i,
  output logic              pal_ready_o,
  output logic              run_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output pix_mode_e         mode_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] FULL_LAST  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SMALL_LAST = ADDR_W'((1 << SMALL_W) - 1);

  ld_state_e         st_q;
  logic [ADDR_W-1:0] cnt_q;
  pix_mode_e         mode_q;
  logic              err_q;
  pix_mode_e         dec_mode;
  logic              dec_res;
  logic [ADDR_W-1:0] last;

  fpl_hdr_decode u_dec (
    .code_i     (pal_data_i[CODE_LSB+1:CODE_LSB]),
    .passive_i  (passive_i),
    .mode_o     (dec_mode),
    .reserved_o (dec_res)
  );

  assign pal_ready_o = (st_q == ST_LOAD);
  assign run_o       = (st_q == ST_RUN);
  assign wr_en_o     = pal_ready_o & pal_valid_i;
  assign wr_addr_o   = cnt_q;
  assign mode_o      = mode_q;
  assign err_o       = err_q;
  assign last        = (mode_q == PM_8B) ? FULL_LAST : SMALL_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= PM_4B;
      err_q  <= 1'b0;
    end else if (frame_start_i) begin
      st_q  <= ST_LOAD;
      cnt_q <= '0;
    end else if (wr_en_o) begin
      if (cnt_q == '0) begin
        mode_q <= dec_mode;
        err_q  <= dec_res;
      end
      if (cnt_q != '0 && cnt_q == last) begin
        st_q  <= ST_RUN;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpl_store.sv
module fpl_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/frame_palette_lut.sv
module frame_palette_lut
  import fpl_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int SMALL_W  = 4,
  parameter int NARROW_W = 12,
  parameter int CODE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              passive_i,
  input  logic              frame_start_i,
  input  logic              pal_valid_i,
  input  logic [WORD_W-1:0] pal_data_i,
  output logic              pal_ready_o,
  input  logic              px_valid_i,
  input  logic [WORD_W-1:0] px_index_i,
  output logic              px_ready_o,
  output logic              col_valid_o,
  output logic [WORD_W-1:0] col_data_o,
  output logic [1:0]        mode_o,
  output logic              cfg_err_o
);
  localparam logic [WORD_W-1:0] NARROW_MASK = WORD_W'((1 << NARROW_W) - 1);

  pix_mode_e         mode;
  logic              run;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              accept;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic              byp_sel_q;
  logic [WORD_W-1:0] byp_q;
  logic              vld_q;

  fpl_load_ctrl #(
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W),
    .SMALL_W  (SMALL_W),
    .CODE_LSB (CODE_LSB)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .frame_start_i (frame_start_i),
    .pal_valid_i   (pal_valid_i),
    .pal_data_i    (pal_data_i),
    .passive_i     (passive_i),
    .pal_ready_o   (pal_ready_o),
    .run_o         (run),
    .wr_en_o       (wr_en),
    .wr_addr_o     (wr_addr),
    .mode_o        (mode),
    .err_o         (cfg_err_o)
  );

  assign px_ready_o = run;
  assign accept     = px_valid_i & run;
  assign rd_addr    = (mode == PM_8B) ? px_index_i[ADDR_W-1:0]
                                      : ADDR_W'(px_index_i[SMALL_W-1:0]);

  fpl_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (WORD_W)
  ) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (pal_data_i),
    .rd_en_i   (accept),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      byp_sel_q <= 1'b0;
      byp_q     <= '0;
    end else begin
      vld_q <= accept;
      if (accept) begin
        byp_sel_q <= (mode == PM_12B) || (mode == PM_16B);
        byp_q     <= (mode == PM_12B) ? (px_index_i & NARROW_MASK) : px_index_i;
      end
    end
  end

  assign col_valid_o = vld_q;
  assign col_data_o  = byp_sel_q ? byp_q : rd_data;
  assign mode_o      = mode;
endmodule

// File: rtl/fpl_checker.sv
module fpl_checker (
  input logic       clk,
  input logic       rst,
  input logic       frame_start_i,
  input logic       pal_ready_o,
  input logic       px_valid_i,
  input logic       px_ready_o,
  input logic       col_valid_o,
  input logic [1:0] mode_o,
  input logic       cfg_err_o
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pal_ready_o && !px_ready_o && !col_valid_o)); // R1

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |=> (pal_ready_o && !px_ready_o)); // R2

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pal_ready_o && px_ready_o)); // R3

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (px_ready_o && $past(px_ready_o)) |-> $stable(mode_o)); // R3

  AST_ERR_AS_4B: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> (mode_o == 2'd0)); // R7

  AST_COL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (px_valid_i && px_ready_o) |=> col_valid_o); // R10

  AST_NO_SPURIOUS_COL: assert property (@(posedge clk) disable iff (rst)
    !(px_valid_i && px_ready_o) |=> !col_valid_o); // R10
endmodule

bind frame_palette_lut fpl_checker u_fpl_checker (
  .clk           (clk),
  .rst           (rst),
  .frame_start_i (frame_start_i),
  .pal_ready_o   (pal_ready_o),
  .px_valid_i    (px_valid_i),
  .px_ready_o    (px_ready_o),
  .col_valid_o   (col_valid_o),
  .mode_o        (mode_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/frame_palette_lut_bench.sv
module frame_palette_lut_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        passive_i = 1'b0;
  logic        frame_start_i = 1'b0;
  logic        pal_valid_i = 1'b0;
  logic [15:0] pal_data_i = '0;
  logic        pal_ready_o;
  logic        px_valid_i = 1'b0;
  logic [15:0] px_index_i = '0;
  logic        px_ready_o;
  logic        col_valid_o;
  logic [15:0] col_data_o;
  logic [1:0]  mode_o;
  logic        cfg_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_palette_lut u_frame_palette_lut (
    .clk           (clk),
    .rst           (rst),
    .passive_i     (passive_i),
    .frame_start_i (frame_start_i),
    .pal_valid_i   (pal_valid_i),
    .pal_data_i    (pal_data_i),
    .pal_ready_o   (pal_ready_o),
    .px_valid_i    (px_valid_i),
    .px_index_i    (px_index_i),
    .px_ready_o    (px_ready_o),
    .col_valid_o   (col_valid_o),
    .col_data_o    (col_data_o),
    .mode_o        (mode_o),
    .cfg_err_o     (cfg_err_o)
  );

  // 4-bit frame lookups: index pattern, entry = index[3:0] (R8)
  localparam logic [15:0] TBL_IDX [8] = '{
    16'h0000, 16'h0003, 16'hFFF3, 16'h000F,
    16'h0010, 16'h1238, 16'h00A9, 16'h8001
  };

  function automatic logic [15:0] palword(input logic [1:0] code,
                                          input logic [15:0] seed, input int k);
    if (k == 0) return (16'(code) << 12) | 16'h0005;
    return seed ^ 16'(k * 257);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_frame(input logic [1:0] code, input logic [15:0] seed,
                            input int nwords, input string req, input bit probe);
    bit early;
    @(negedge clk) frame_start_i = 1'b1;
    @(negedge clk) frame_start_i = 1'b0;
    check(pal_ready_o && !px_ready_o, "R2", {pal_ready_o, px_ready_o}, 2'b10);
    if (probe) begin
      px_valid_i = 1'b1; px_index_i = 16'h0001;
      @(negedge clk) px_valid_i = 1'b0;
      check(!col_valid_o, "R10", col_valid_o, 0);
    end
    early = 1'b0;
    for (int k = 0; k < nwords; k++) begin
      if (!pal_ready_o) early = 1'b1;
      pal_valid_i = 1'b1;
      pal_data_i  = palword(code, seed, k);
      @(negedge clk);
    end
    pal_valid_i = 1'b0;
    check(!early, req, early, 0);
    check(!pal_ready_o && px_ready_o, req, {pal_ready_o, px_ready_o}, 2'b01);
  endtask

  task automatic lookup(input logic [15:0] idx, input logic [15:0] exp,
                        input string req);
    @(negedge clk) begin px_valid_i = 1'b1; px_index_i = idx; end
    @(negedge clk) px_valid_i = 1'b0;
    check(col_valid_o && col_data_o == exp, req, {15'd0, col_valid_o, col_data_o},
          {16'd1, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!pal_ready_o && !px_ready_o && !col_valid_o && !cfg_err_o && mode_o == 2'd0,
          "R1", {pal_ready_o, px_ready_o, col_valid_o, cfg_err_o, mode_o}, 0);

    // R3 4-bit frame, stalled lookup probe for R10
    load_frame(2'b00, 16'h1234, 16, "R3", 1'b1);
    check(mode_o == 2'd0, "R3", mode_o, 0);
    for (int i = 0; i < 8; i++)
      lookup(TBL_IDX[i], palword(2'b00, 16'h1234, int'(TBL_IDX[i][3:0])), "R8");
    lookup(16'h0000, 16'h0005, "R11");

    // R4 / R9 8-bit frame
    load_frame(2'b01, 16'h4321, 256, "R4", 1'b0);
    check(mode_o == 2'd1, "R4", mode_o, 1);
    lookup(16'h00FF, palword(2'b01, 16'h4321, 255), "R9");
    lookup(16'h01A5, palword(2'b01, 16'h4321, 16'hA5), "R9");
    lookup(16'h0010, palword(2'b01, 16'h4321, 16), "R9");
    lookup(16'hFF00, 16'h1005, "R11");

    // R5 12-bit bypass
    passive_i = 1'b1;
    load_frame(2'b10, 16'h0000, 16, "R5", 1'b0);
    check(mode_o == 2'd2, "R5", mode_o, 2);
    lookup(16'hBEEF, 16'h0EEF, "R5");

    // R6 16-bit bypass
    passive_i = 1'b0;
    load_frame(2'b10, 16'h0000, 16, "R6", 1'b0);
    check(mode_o == 2'd3, "R6", mode_o, 3);
    lookup(16'hBEEF, 16'hBEEF, "R6");

    // R7 reserved code
    load_frame(2'b11, 16'h7777, 16, "R7", 1'b0);
    check(cfg_err_o && mode_o == 2'd0, "R7", {cfg_err_o, mode_o}, 3'b100);
    lookup(16'h0047, palword(2'b11, 16'h7777, 7), "R7");
    load_frame(2'b00, 16'h2222, 16, "R7", 1'b0);
    check(!cfg_err_o, "R7", cfg_err_o, 0);
    lookup(16'h0002, palword(2'b00, 16'h2222, 2), "R8");

    // R10 no output without a valid index
    @(negedge clk);
    check(!col_valid_o, "R10", col_valid_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule